// File: doc/BRIEF.md
# Flash Row Program-Verify Sequencer

This block runs the repeated program-and-check loop for a single 128-byte row of flash memory. Software or a host engine first loads a row start address and up to 128 data bytes through a byte port. A start request then launches the loop. Each pass streams a 128-byte image to the flash write path and asks an external pulse timer for a programming pulse of a chosen class. The row is then read back as 64 sixteen-bit words. Two working images are updated bit by bit from each readback.

The first working image, called the reprogram mask, marks with a 0 every bit that still has to be driven low. It is rebuilt from the original data and the newest readback, so a bit that slips back after an earlier success is driven again. The second working image, called the top-up mask, is only used in the early passes. It receives a short extra pulse on the bits that have just reached their programmed state. After the early passes only long pulses are used.

The loop ends when a readback matches the original data, which raises `done`. It also ends when the last permitted pass still mismatches, which raises both `done` and `fail`. Both flags hold until the next load begins.

Top module: `flash_row_prog_ctrl`

## Requirements
- R1: A start request whose latched row address has any of bits 6:0 set raises `done` and `fail` on the next clock edge, with no write stream and no pulse request.
- R2: A load begins with `ld_start` and sets every row byte to 0xFF. Loaded bytes then fill offsets 0, 1, 2 and so on in order. Bytes offered after 128 have been taken are ignored.
- R3: Before every pulse request the block presents exactly 128 bytes on consecutive cycles with `wr_valid` high, at addresses row base + 0 through row base + 127 in ascending order.
- R4: The image streamed before a normal or long pulse is the loaded data on the first pass. On every later pass it is D | ~V, bitwise, where D is the loaded data and V is the latest readback. Within a readback word, bits 15:8 belong to the even byte offset and bits 7:0 to the odd one.
- R5: In the early passes, the image streamed before the extra pulse is X' | V. Here X' is the reprogram image that was streamed for that pass's normal pulse and V is that pass's readback.
- R6: `pls_sel` encodes the pulse class: 0 normal, 1 extra, 2 long. Passes 1 to N1 each issue a normal pulse and, after the readback, an extra pulse. Passes N1+1 to N1+N2 issue a single long pulse.
- R7: After each normal or long pulse the block issues 64 reads at byte addresses row base + 2w, for w = 0 to 63 in ascending order. It waits for `vf_rvalid` on each read before issuing the next.
- R8: A pass whose 64 readback words all equal the loaded data ends the loop with `done` high and `fail` low. In the early passes this happens after that pass's extra pulse.
- R9: If pass N1+N2 still mismatches, the loop ends with `done` and `fail` both high, and no further write, pulse or read activity follows.
- R10: `done` and `fail` are low after reset. Once raised, they keep their values until the next `ld_start`, which clears them.
- R11: A bit that read back correctly in one pass but reads back wrong in a later pass is 0 again in the next reprogram image.
- R12: `pls_req` is high for exactly one cycle per pulse. No new request is made before `pls_ack` has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_start | input | 1 | Begin a new row load; latches `ld_addr` |
| ld_addr | input | ADDR_W | Row start byte address |
| ld_valid | input | 1 | One data byte offered on `ld_byte` |
| ld_byte | input | 8 | Row data byte |
| go | input | 1 | Start the program-verify loop |
| wr_valid | output | 1 | A write-stream byte is present |
| wr_addr | output | ADDR_W | Byte address of the write-stream byte |
| wr_byte | output | 8 | Write-stream byte |
| pls_req | output | 1 | One-cycle request for a programming pulse |
| pls_sel | output | 2 | Pulse class: 0 normal, 1 extra, 2 long |
| pls_ack | input | 1 | Pulse timer finished |
| vf_rd | output | 1 | One-cycle readback request |
| vf_addr | output | ADDR_W | Byte address of the requested word |
| vf_rdata | input | 16 | Readback word (bits 15:8 at the even address) |
| vf_rvalid | input | 1 | `vf_rdata` is valid |
| done | output | 1 | Loop finished |
| fail | output | 1 | Loop finished without a clean readback |

## Verification
The bench models the flash row with a per-bit count of pulses needed. This lets it set up several distinct rows:
- A row where every bit programs on the first pulse exercises the shortest normal-plus-extra sequence.
- A partly loaded row with one slow bit proves the 0xFF fill and a second pass. A full-row load with two extra bytes that must be dropped shows the 128-byte limit.
- A slow bit that needs more passes than N1 shows the switch to long pulses and the end of the extra pulses.
- A bit that leaks back to erased after verifying tells a recomputed reprogram mask apart from an accumulated one.
- A bit that reads 0 where the data holds 1 can never match, which forces the pass-limit failure.
- A misaligned start address must fail without any flash traffic.

// File: rtl/flash_row_prog_ctrl.sv
module flash_row_prog_ctrl #(
  parameter int ADDR_W = 24,
  parameter int N1     = 6,
  parameter int N2     = 994
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              ld_valid,
  input  logic [7:0]        ld_byte,
  input  logic              go,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_byte,
  output logic              pls_req,
  output logic [1:0]        pls_sel,
  input  logic              pls_ack,
  output logic              vf_rd,
  output logic [ADDR_W-1:0] vf_addr,
  input  logic [15:0]       vf_rdata,
  input  logic              vf_rvalid,
  output logic              done,
  output logic              fail
);

  localparam int ROW_BYTES = 128;
  localparam int WORDS     = ROW_BYTES / 2;
  localparam int BW        = $clog2(ROW_BYTES);
  localparam int WW        = $clog2(WORDS);
  localparam int PASS_MAX  = N1 + N2;
  localparam int PW        = $clog2(PASS_MAX + 1);
  localparam logic [PW-1:0] SHORT_LAST = PW'(N1);
  localparam logic [PW-1:0] LAST_PASS  = PW'(PASS_MAX);
  localparam logic [PW-1:0] FIRST_PASS = PW'(1);
  localparam logic [WW-1:0] LAST_WORD  = WW'(WORDS - 1);
  localparam logic [BW-1:0] LAST_BYTE  = BW'(ROW_BYTES - 1);
  localparam logic [1:0] SEL_NORM = 2'd0;
  localparam logic [1:0] SEL_ADD  = 2'd1;
  localparam logic [1:0] SEL_LONG = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_PULSE, S_WAIT, S_VREAD, S_VWAIT, S_DONE
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] base;
  logic [BW:0]       lcnt;
  logic [BW-1:0]     idx;
  logic [WW-1:0]     widx;
  logic [PW-1:0]     pass;
  logic              addl, mism, done_q, fail_q;

  logic [15:0] dbuf [WORDS];
  logic [15:0] xbuf [WORDS];
  logic [15:0] abuf [WORDS];

  wire short_ph  = pass <= SHORT_LAST;
  wire can_load  = (st == S_IDLE) || (st == S_DONE);
  wire take_byte = (st == S_IDLE) && !ld_start && ld_valid && !lcnt[BW];
  wire launch    = (st == S_IDLE) && !ld_start && !ld_valid && go;
  wire aligned   = base[BW-1:0] == '0;

  wire [15:0] dw    = dbuf[widx];
  wire [15:0] xw    = xbuf[widx];
  wire [15:0] src_w = addl ? abuf[idx[BW-1:1]] : xbuf[idx[BW-1:1]];

  wire word_hit  = (st == S_VWAIT) && vf_rvalid;
  wire last_word = widx == LAST_WORD;
  wire mism_nx   = mism | (vf_rdata != dw);
  wire end_add   = (st == S_WAIT) && pls_ack && addl;
  wire end_long  = word_hit && last_word && !short_ph;
  wire pass_end  = end_add || end_long;
  wire pass_bad  = end_add ? mism : mism_nx;

  assign wr_valid = st == S_WRITE;
  assign wr_addr  = {base[ADDR_W-1:BW], idx};
  assign wr_byte  = idx[0] ? src_w[7:0] : src_w[15:8];
  assign pls_req  = st == S_PULSE;
  assign pls_sel  = addl ? SEL_ADD : (short_ph ? SEL_NORM : SEL_LONG);
  assign vf_rd    = st == S_VREAD;
  assign vf_addr  = {base[ADDR_W-1:BW], widx, 1'b0};
  assign done     = done_q;
  assign fail     = fail_q;

  always_ff @(posedge clk) begin
    if (can_load && ld_start) begin
      for (int w = 0; w < WORDS; w++) dbuf[w] <= 16'hFFFF;
    end else if (take_byte) begin
      if (lcnt[0]) dbuf[lcnt[BW-1:1]][7:0]  <= ld_byte;
      else         dbuf[lcnt[BW-1:1]][15:8] <= ld_byte;
    end
    if (launch && aligned) begin
      for (int w = 0; w < WORDS; w++) xbuf[w] <= dbuf[w];
    end
    if (word_hit) begin
      xbuf[widx] <= dw | ~vf_rdata;
      if (short_ph) abuf[widx] <= xw | vf_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      base   <= '0;
      lcnt   <= '0;
      idx    <= '0;
      widx   <= '0;
      pass   <= '0;
      addl   <= 1'b0;
      mism   <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      if (can_load && ld_start) begin
        st     <= S_IDLE;
        base   <= ld_addr;
        lcnt   <= '0;
        done_q <= 1'b0;
        fail_q <= 1'b0;
      end else begin
        unique case (st)
          S_IDLE: begin
            if (take_byte) lcnt <= lcnt + 1'b1;
            else if (launch) begin
              if (!aligned) begin
                done_q <= 1'b1;
                fail_q <= 1'b1;
                st     <= S_DONE;
              end else begin
                pass <= FIRST_PASS;
                addl <= 1'b0;
                idx  <= '0;
                st   <= S_WRITE;
              end
            end
          end
          S_WRITE: begin
            idx <= idx + 1'b1;
            if (idx == LAST_BYTE) st <= S_PULSE;
          end
          S_PULSE: st <= S_WAIT;
          S_WAIT: begin
            if (pls_ack && !addl) begin
              widx <= '0;
              mism <= 1'b0;
              st   <= S_VREAD;
            end
          end
          S_VREAD: st <= S_VWAIT;
          S_VWAIT: begin
            if (vf_rvalid) begin
              mism <= mism_nx;
              if (!last_word) begin
                widx <= widx + 1'b1;
                st   <= S_VREAD;
              end else if (short_ph) begin
                addl <= 1'b1;
                idx  <= '0;
                st   <= S_WRITE;
              end
            end
          end
          default: ;
        endcase
        if (pass_end) begin
          if (!pass_bad) begin
            done_q <= 1'b1;
            st     <= S_DONE;
          end else if (pass >= LAST_PASS) begin
            done_q <= 1'b1;
            fail_q <= 1'b1;
            st     <= S_DONE;
          end else begin
            pass <= pass + 1'b1;
            addl <= 1'b0;
            idx  <= '0;
            st   <= S_WRITE;
          end
        end
      end
    end
  end

  p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pls_req |=> !pls_req);

  p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pls_req |-> pls_sel != 2'd3);

  p_one_port_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_valid, pls_req, vf_rd}));

  p_fail_has_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && !pls_req && !vf_rd);

  p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !ld_start |=> done && $stable(fail));

  p_ack_then_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pls_req |=> !wr_valid && !vf_rd);

endmodule

// File: tb/flash_row_prog_ctrl_tb.sv
module flash_row_prog_ctrl_tb_top;
  localparam int N1 = 3;
  localparam int N2 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_start = 1'b0, ld_valid = 1'b0, go = 1'b0;
  logic [23:0] ld_addr = '0;
  logic [7:0]  ld_byte = '0;
  logic        wr_valid, pls_req, vf_rd, done, fail;
  logic [23:0] wr_addr, vf_addr;
  logic [7:0]  wr_byte;
  logic [1:0]  pls_sel;
  logic        pls_ack = 1'b0, vf_rvalid = 1'b0;
  logic [15:0] vf_rdata = '0;

  always #10 clk = ~clk;

  flash_row_prog_ctrl #(.ADDR_W(24), .N1(N1), .N2(N2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
    .ld_valid(ld_valid), .ld_byte(ld_byte), .go(go),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .pls_req(pls_req), .pls_sel(pls_sel), .pls_ack(pls_ack),
    .vf_rd(vf_rd), .vf_addr(vf_addr), .vf_rdata(vf_rdata), .vf_rvalid(vf_rvalid),
    .done(done), .fail(fail));

  int errors = 0, checks = 0;
  int sel_q[$];
  int res_q[$];

  logic [7:0] dmem [128], flash [128], wbuf [128], xexp [128], aexp [128];
  int stub [1024];
  logic [23:0] rbase;
  int bpass, wcount, vexp_w, rd_off, pulses, vaddr_err, addr_err, diffs, off, e;
  bit ack_pend, rd_pend, prev_done, req_out, ack_prev;
  bit leak_en;
  int leak_byte, leak_bit;
  logic [15:0] rv;
  logic [7:0] vb;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int s);
    return 8'((k * 37 + s * 11 + 5) & 255);
  endfunction

  // scoreboard monitor: models the flash row, serves the handshakes, pops expectations
  always @(negedge clk) begin
    if (ack_prev) req_out = 0;
    ack_prev = ack_pend;
    pls_ack = ack_pend; ack_pend = 0;
    vf_rvalid = rd_pend;
    if (rd_pend) begin
      rv = {flash[rd_off], flash[rd_off + 1]};
      vf_rdata = rv;
      for (int h = 0; h < 2; h++) begin
        vb = (h == 0) ? rv[15:8] : rv[7:0];
        if (bpass <= N1) aexp[rd_off + h] = xexp[rd_off + h] | vb;
        xexp[rd_off + h] = dmem[rd_off + h] | ~vb;
      end
    end
    rd_pend = 0;
    if (wr_valid) begin
      off = int'(wr_addr) - int'(rbase);
      if (off != wcount || off < 0 || off > 127) begin
        addr_err++;
      end else wbuf[off] = wr_byte;
      wcount++;
    end
    if (pls_req) begin
      pulses++;
      chk(!req_out, "R12", 1, 0);
      req_out = 1;
      chk(wcount == 128, "R3", wcount, 128);
      diffs = 0;
      for (int b = 0; b < 128; b++)
        if (wbuf[b] !== ((pls_sel == 2'd1) ? aexp[b] : xexp[b])) diffs++;
      if (pls_sel == 2'd1) chk(diffs == 0, "R5", diffs, 0);
      else if (bpass == 0) chk(diffs == 0, "R2", diffs, 0);
      else chk(diffs == 0, "R4", diffs, 0);
      if (sel_q.size() == 0) chk(0, "R6", int'(pls_sel), -1);
      else begin
        e = sel_q.pop_front();
        chk(int'(pls_sel) == e, "R6", int'(pls_sel), e);
      end
      if (leak_en && pls_sel == 2'd0 && bpass == 2)
        chk(wbuf[leak_byte][leak_bit] == 1'b0, "R11", int'(wbuf[leak_byte][leak_bit]), 0);
      if (pls_sel != 2'd1) begin
        bpass++;
        for (int b = 0; b < 128; b++)
          for (int i = 0; i < 8; i++)
            if (!wbuf[b][i] && flash[b][i]) begin
              stub[b * 8 + i]--;
              if (stub[b * 8 + i] <= 0) flash[b][i] = 1'b0;
            end
        if (leak_en && bpass == 2) begin
          flash[leak_byte][leak_bit] = 1'b1;
          stub[leak_byte * 8 + leak_bit] = 1;
        end
      end
      wcount = 0;
      vexp_w = 0;
      ack_pend = 1;
    end
    if (vf_rd) begin
      off = int'(vf_addr) - int'(rbase);
      if (off != 2 * vexp_w || off < 0 || off > 126) begin
        vaddr_err++;
        rd_off = 0;
      end else rd_off = off;
      vexp_w++;
      rd_pend = 1;
    end
    if (done && !prev_done) begin
      if (res_q.size() == 0) chk(0, "R8", int'(fail), -1);
      else begin
        e = res_q.pop_front();
        chk(int'(fail) == e, e ? "R9" : "R8", int'(fail), e);
      end
    end
    prev_done = done;
  end

  function automatic int first_bit(input logic [7:0] v, input bit val);
    for (int i = 0; i < 8; i++) if (v[i] == val) return i;
    return 0;
  endfunction

  // driver: loads a row, pushes the expected pulse classes and outcome
  task automatic run_row(input logic [23:0] addr, input int nload, input int seed,
                         input int passes, input bit exp_fail, input int stub_cnt,
                         input bit leak, input bit overprog);
    bit alg;
    alg = (addr[6:0] == 7'd0);
    for (int k = 0; k < 128; k++) begin
      dmem[k]  = (k < nload) ? pat(k, seed) : 8'hFF;
      flash[k] = 8'hFF;
      xexp[k]  = dmem[k];
      aexp[k]  = 8'hFF;
      wbuf[k]  = 8'h00;
    end
    for (int i = 0; i < 1024; i++) stub[i] = 1;
    dmem[3] = (nload > 3) ? dmem[3] : dmem[3];
    if (stub_cnt > 1) stub[3 * 8 + first_bit(dmem[3], 1'b0)] = stub_cnt;
    leak_en = leak;
    leak_byte = 7;
    leak_bit = first_bit(dmem[7], 1'b0);
    if (overprog) flash[5][first_bit(dmem[5], 1'b1)] = 1'b0;
    bpass = 0; wcount = 0; vexp_w = 0; pulses = 0; vaddr_err = 0; addr_err = 0;
    rbase = addr;
    if (alg)
      for (int n = 1; n <= passes; n++) begin
        sel_q.push_back((n <= N1) ? 0 : 2);
        if (n <= N1) sel_q.push_back(1);
      end
    res_q.push_back(int'(exp_fail));
    @(negedge clk);
    ld_start = 1; ld_addr = addr;
    @(negedge clk);
    ld_start = 0;
    for (int k = 0; k < nload; k++) begin
      ld_valid = 1;
      ld_byte = (k < 128) ? pat(k, seed) : 8'h00;
      @(negedge clk);
    end
    ld_valid = 0;
    go = 1;
    @(negedge clk);
    go = 0;
    if (!alg) begin
      chk(done == 1'b1 && fail == 1'b1, "R1", int'({done, fail}), 3);
    end
    while (!done) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(done == 1'b1 && fail == exp_fail, "R10", int'({done, fail}), int'({1'b1, exp_fail}));
    chk(sel_q.size() == 0, "R6", sel_q.size(), 0);
    chk(vaddr_err == 0, "R7", vaddr_err, 0);
    chk(addr_err == 0, "R3", addr_err, 0);
    if (!alg) chk(pulses == 0, "R1", pulses, 0);
    else if (exp_fail) chk(bpass == N1 + N2, "R9", bpass, N1 + N2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !fail && !wr_valid && !pls_req && !vf_rd, "R10",
        int'({done, fail, wr_valid, pls_req, vf_rd}), 0);
    rst_n = 1;
    @(negedge clk);
    // full row plus two extra bytes that must be dropped; single pass
    run_row(24'h001200, 130, 1, 1, 1'b0, 1, 1'b0, 1'b0);
    // partial row with FF fill and a bit that needs two pulses
    run_row(24'h003480, 10, 2, 2, 1'b0, 2, 1'b0, 1'b0);
    // slow bit beyond N1: long pulses take over
    run_row(24'h005600, 128, 3, 5, 1'b0, 5, 1'b0, 1'b0);
    // bit leaks back after verifying and must be driven again
    run_row(24'h007880, 128, 4, 3, 1'b0, 2, 1'b1, 1'b0);
    // bit reads 0 where data is 1: never matches, pass limit reached
    run_row(24'h009A00, 128, 5, N1 + N2, 1'b1, 1, 1'b0, 1'b1);
    // misaligned row address
    run_row(24'h001240, 4, 6, 0, 1'b1, 1, 1'b0, 1'b0);
    // ld_start clears the held flags
    @(negedge clk);
    ld_start = 1; ld_addr = 24'h000100;
    @(negedge clk);
    ld_start = 0;
    @(negedge clk);
    chk(!done && !fail, "R10", int'({done, fail}), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule